// File: doc/BRIEF.md
# Infrared Transceiver Serial Configuration Master

This engine programs the control registers of an external infrared transceiver module over a three-wire serial link. It drives a clock line and a data line, and it watches two status lines coming back from the module: an active-low valid flag and a receive data bit. Both returning lines pass through a two-flop synchronizer before the engine looks at them. The host picks an operation, supplies a device address, a register index and a write byte, and pulses `start`. The engine reports `busy` while it works and pulses `done` when it has finished. Read results appear on `rdData`.

There are four operations, selected by `op`:
- `0`: register write.
- `1`: register read.
- `2`: link reset.
- `3`: a canned mode-setup sequence. This resets the link, writes three registers at device address 0x40 (using `wrData` as the mode byte), and reads back the mode register.

All line timing comes from two delay units. Each unit is a whole multiple of a base step counted in system clocks:
- The long unit is `LONG_STEPS` steps.
- The short unit is `SHORT_STEPS` steps.

Top module: `irx_cfg_master`

## Requirements
- R1: The command byte is `devAddr | (regIndex << 1)`, with bit 0 forced to 1 for a write. For a read, bit 0 is left as `devAddr | (regIndex<<1)` gives it.
- R2: Every byte goes out least significant bit first. A data bit is placed on `irData` while `irClk` is low, and `irData` never changes while `irClk` is high.
- R3: A write produces exactly 19 rising clock edges:
  - one preamble pulse with data 0;
  - the 8 command bits;
  - the 8 data bits;
  - two trailing pulses with data 0.
  It ends with `irClk` and `irData` both low.
- R4: A read sends the preamble pulse and the command byte, then holds data low. It then gives up to 10 poll pulses. After each poll pulse, `irData` is driven high and the synchronized `irValidN` is sampled. Polling stops at the first low sample.
- R5: When valid was found, 8 clock pulses follow. The synchronized `irRxBit` is sampled after each falling edge. The result is assembled least significant bit first into `rdData`.
- R6: When no poll sees valid low, exactly 2 dummy pulses follow and `rdData` becomes 0.
- R7: Every read finishes with:
  - one pulse with data high;
  - data driven low;
  - three pulses with data 0;
  - then `irClk` low.
- R8: A reset drives data low and gives exactly 30 clock pulses with data 0, ending with `irClk` and `irData` low.
- R9: The mode-setup operation runs, in this order:
  - a reset;
  - write 0x17 to index 0 of address 0x40;
  - write the mode byte to index 1;
  - write 0xFF to index 2;
  - a read of index 1, whose result lands in `rdData`.
  It raises `done` once, at the end.
- R10: The phases obey these minimum lengths:
  - every clock-high phase lasts at least one long unit;
  - every clock-low phase lasts at least one long unit;
  - `irData` is steady for at least one long unit before every rising clock edge.
- R11: `start` is ignored while `busy` is high. `done` is high for exactly one cycle, in the first cycle with `busy` low. `rdData` changes only while `busy` is high.
- R12: After reset, `irClk`, `irData`, `busy`, `done` and `rdData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 0 write, 1 read, 2 reset, 3 mode setup |
| devAddr | input | 8 | Device address merged into the command byte |
| regIndex | input | 7 | Register index, shifted left by one in the command byte |
| wrData | input | 8 | Write byte, or the mode byte for mode setup |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Last read result |
| irClk | output | 1 | Serial clock to the transceiver |
| irData | output | 1 | Serial data to the transceiver |
| irValidN | input | 1 | Active-low valid flag from the transceiver |
| irRxBit | input | 1 | Receive data bit from the transceiver |

## Verification
The bound assertions check these rules on every cycle:
- the line rule that data holds while the clock is high;
- that the clock rests low when idle;
- the one-cycle `done` and its relation to `busy`;
- that `busy` only starts from a `start` request;
- that `rdData` does not move outside an operation.

Only the bench scenarios can show the following:
- the exact edge sequences of writes, reads, resets and the mode-setup chain;
- where polling stops for each valid position, including the first and tenth poll and no valid at all;
- the assembled read byte;
- the minimum phase lengths.

// File: rtl/irx_cfg_pkg.sv
package irx_cfg_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_RESET = 2'd2,
    OP_MODE  = 2'd3
  } opCode_e;

  typedef enum logic [1:0] {
    W_LONG   = 2'd0,
    W_LONG2  = 2'd1,
    W_SETTLE = 2'd2
  } waitSel_e;

  localparam int CNT_W        = 5;
  localparam int BYTE_BITS    = 8;
  localparam int POLL_LIMIT   = 10;
  localparam int DUMMY_PULSES = 2;
  localparam int TRAIL_PULSES = 2;
  localparam int END_PULSES   = 3;
  localparam int RESET_PULSES = 30;
  localparam int LAST_STEP    = 4;

  localparam logic [7:0] MODE_DEV_ADDR = 8'h40;
  localparam logic [7:0] MODE_CFG0     = 8'h17;
  localparam logic [7:0] MODE_CFG2     = 8'hFF;

  typedef struct packed {
    opCode_e    op;
    logic [7:0] cmd;
    logic [7:0] data;
  } opDesc_t;

  // strobes from the sequencer to the line datapath
  typedef struct packed {
    logic             startWait;
    waitSel_e         waitSel;
    logic             clkSet;
    logic             clkClr;
    logic             dataDrv;
    logic             dataVal;
    logic             dataFromTx;
    logic             loadTx;
    logic [7:0]       txByte;
    logic             shiftTx;
    logic             loadCnt;
    logic [CNT_W-1:0] cntVal;
    logic             decCnt;
    logic             clrRx;
    logic             sampleRx;
    logic             commitRx;
  } dpCtl_t;

  function automatic opDesc_t seqDesc(input logic [2:0] idx, input logic [7:0] mode);
    opDesc_t d;
    d.op   = OP_WRITE;
    d.data = 8'h00;
    d.cmd  = 8'h00;
    case (idx)
      3'd0: d.op = OP_RESET;
      3'd1: begin d.cmd = MODE_DEV_ADDR | 8'h01; d.data = MODE_CFG0; end
      3'd2: begin d.cmd = MODE_DEV_ADDR | 8'h03; d.data = mode; end
      3'd3: begin d.cmd = MODE_DEV_ADDR | 8'h05; d.data = MODE_CFG2; end
      default: begin d.op = OP_READ; d.cmd = MODE_DEV_ADDR | 8'h02; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/irx_cfg_sync.sv
module irx_cfg_sync #(
  parameter int           WIDTH   = 2,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stg[i] <= RST_VAL;
      else       stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irx_cfg_dp.sv
module irx_cfg_dp
  import irx_cfg_pkg::*;
#(
  parameter int LONG_CLKS  = 320,
  parameter int SHORT_CLKS = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic       validNIn,
  input  logic       rxBitIn,
  output logic       sclk,
  output logic       sdata,
  output logic [7:0] rdData,
  output logic       tmrDone,
  output logic       cntLast,
  output logic       validSeen
);
  localparam int SETTLE_CLKS = 2*LONG_CLKS + SHORT_CLKS;
  localparam int TMR_W       = $clog2(SETTLE_CLKS + 1);

  logic [TMR_W-1:0] tmr, tmrLoad;
  logic [7:0]       txSh, rxSh;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       syncOut;

  irx_cfg_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b10)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({validNIn, rxBitIn}),
    .dout(syncOut)
  );

  always_comb begin
    case (ctl.waitSel)
      W_LONG:  tmrLoad = TMR_W'(LONG_CLKS);
      W_LONG2: tmrLoad = TMR_W'(2*LONG_CLKS);
      default: tmrLoad = TMR_W'(SETTLE_CLKS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr    <= '0;
      sclk   <= 1'b0;
      sdata  <= 1'b0;
      txSh   <= '0;
      cnt    <= '0;
      rxSh   <= '0;
      rdData <= '0;
    end else begin
      if (ctl.startWait)    tmr <= tmrLoad;
      else if (tmr != '0)   tmr <= tmr - 1'b1;

      if (ctl.clkSet)       sclk <= 1'b1;
      else if (ctl.clkClr)  sclk <= 1'b0;

      if (ctl.dataFromTx)   sdata <= txSh[0];
      else if (ctl.dataDrv) sdata <= ctl.dataVal;

      if (ctl.loadTx)       txSh <= ctl.txByte;
      else if (ctl.shiftTx) txSh <= {1'b0, txSh[7:1]};

      if (ctl.loadCnt)      cnt <= ctl.cntVal;
      else if (ctl.decCnt)  cnt <= cnt - 1'b1;

      if (ctl.clrRx)         rxSh <= '0;
      else if (ctl.sampleRx) rxSh <= {syncOut[0], rxSh[7:1]};

      if (ctl.commitRx)     rdData <= rxSh;
    end
  end

  assign tmrDone   = (tmr == '0);
  assign cntLast   = (cnt == CNT_W'(1));
  assign validSeen = ~syncOut[1];
endmodule

// File: rtl/irx_cfg_ctrl.sv
module irx_cfg_ctrl
  import irx_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  opCode_e    op,
  input  logic [7:0] devAddr,
  input  logic [6:0] regIndex,
  input  logic [7:0] wrData,
  input  logic       tmrDone,
  input  logic       cntLast,
  input  logic       validSeen,
  output dpCtl_t     ctl,
  output logic       busy,
  output logic       done
);
  typedef enum logic [4:0] {
    S_IDLE, S_PRE_LO, S_PRE_HI, S_BIT_LO, S_BIT_HI, S_TRL_LO, S_TRL_HI,
    S_RD_HOLD, S_POLL_HI, S_POLL_LO, S_POLL_DH, S_DAT_HI, S_DAT_LO,
    S_DUM_HI, S_DUM_LO, S_TAIL_HI, S_TAIL_LO, S_TAIL_DL, S_END_HI,
    S_END_LO, S_RST_LO0, S_RST_HI, S_RST_LO, S_FIN
  } state_e;

  state_e     state, nextState;
  logic       waiting, byteSel, inSeq, advByte, opEnd;
  logic [2:0] seqIdx;
  logic [7:0] modeReg;
  opDesc_t    cur, startDesc, nextDesc;

  function automatic state_e firstState(input opCode_e o);
    return (o == OP_RESET) ? S_RST_LO0 : S_PRE_LO;
  endfunction

  always_comb begin
    if (op == OP_MODE) begin
      startDesc = seqDesc(3'd0, wrData);
    end else begin
      startDesc.op   = op;
      startDesc.cmd  = devAddr | {regIndex, 1'b0} | {7'b0, op == OP_WRITE};
      startDesc.data = wrData;
    end
    nextDesc = seqDesc(seqIdx + 3'd1, modeReg);
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    advByte   = 1'b0;
    opEnd     = 1'b0;
    if (state != S_IDLE && !waiting) begin
      ctl.startWait = 1'b1;
      ctl.waitSel   = W_LONG;
      case (state)
        S_PRE_LO, S_TRL_LO, S_RD_HOLD: begin
          ctl.clkClr = 1'b1; ctl.dataDrv = 1'b1; ctl.waitSel = W_LONG2;
        end
        S_BIT_LO: begin
          ctl.clkClr = 1'b1; ctl.dataFromTx = 1'b1; ctl.waitSel = W_SETTLE;
        end
        S_PRE_HI, S_BIT_HI, S_TRL_HI, S_POLL_HI, S_DAT_HI, S_DUM_HI,
        S_TAIL_HI, S_END_HI, S_RST_HI: ctl.clkSet = 1'b1;
        S_DAT_LO, S_DUM_LO, S_TAIL_LO, S_END_LO: begin
          ctl.clkClr = 1'b1; ctl.waitSel = W_LONG2;
        end
        S_POLL_DH: begin ctl.dataDrv = 1'b1; ctl.dataVal = 1'b1; end
        S_TAIL_DL: ctl.dataDrv = 1'b1;
        S_RST_LO0: begin ctl.clkClr = 1'b1; ctl.dataDrv = 1'b1; end
        default:   ctl.clkClr = 1'b1;
      endcase
    end else if (state != S_IDLE && tmrDone) begin
      case (state)
        S_PRE_LO:  nextState = S_PRE_HI;
        S_PRE_HI: begin
          ctl.loadTx = 1'b1; ctl.txByte = cur.cmd;
          ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(BYTE_BITS);
          nextState = S_BIT_LO;
        end
        S_BIT_LO:  nextState = S_BIT_HI;
        S_BIT_HI: begin
          ctl.shiftTx = 1'b1; ctl.decCnt = 1'b1;
          if (!cntLast) begin
            nextState = S_BIT_LO;
          end else if (cur.op == OP_WRITE && !byteSel) begin
            ctl.loadTx = 1'b1; ctl.txByte = cur.data;
            ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(BYTE_BITS);
            advByte = 1'b1;
            nextState = S_BIT_LO;
          end else if (cur.op == OP_WRITE) begin
            ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(TRAIL_PULSES);
            nextState = S_TRL_LO;
          end else begin
            nextState = S_RD_HOLD;
          end
        end
        S_TRL_LO:  nextState = S_TRL_HI;
        S_TRL_HI: begin
          ctl.decCnt = 1'b1;
          nextState = cntLast ? S_FIN : S_TRL_LO;
        end
        S_RD_HOLD: begin
          ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(POLL_LIMIT); ctl.clrRx = 1'b1;
          nextState = S_POLL_HI;
        end
        S_POLL_HI: nextState = S_POLL_LO;
        S_POLL_LO: nextState = S_POLL_DH;
        S_POLL_DH: begin
          if (validSeen) begin
            ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(BYTE_BITS);
            nextState = S_DAT_HI;
          end else if (cntLast) begin
            ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(DUMMY_PULSES);
            nextState = S_DUM_HI;
          end else begin
            ctl.decCnt = 1'b1;
            nextState = S_POLL_HI;
          end
        end
        S_DAT_HI:  nextState = S_DAT_LO;
        S_DAT_LO: begin
          ctl.sampleRx = 1'b1; ctl.decCnt = 1'b1;
          nextState = cntLast ? S_TAIL_HI : S_DAT_HI;
        end
        S_DUM_HI:  nextState = S_DUM_LO;
        S_DUM_LO: begin
          ctl.decCnt = 1'b1;
          nextState = cntLast ? S_TAIL_HI : S_DUM_HI;
        end
        S_TAIL_HI: nextState = S_TAIL_LO;
        S_TAIL_LO: nextState = S_TAIL_DL;
        S_TAIL_DL: begin
          ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(END_PULSES);
          nextState = S_END_HI;
        end
        S_END_HI:  nextState = S_END_LO;
        S_END_LO: begin
          ctl.decCnt = 1'b1;
          if (cntLast) begin ctl.commitRx = 1'b1; nextState = S_FIN; end
          else nextState = S_END_HI;
        end
        S_RST_LO0: begin
          ctl.loadCnt = 1'b1; ctl.cntVal = CNT_W'(RESET_PULSES);
          nextState = S_RST_HI;
        end
        S_RST_HI:  nextState = S_RST_LO;
        S_RST_LO: begin
          ctl.decCnt = 1'b1;
          nextState = cntLast ? S_FIN : S_RST_HI;
        end
        default: begin
          opEnd = 1'b1;
          nextState = S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waiting <= 1'b0;
      byteSel <= 1'b0;
      inSeq   <= 1'b0;
      seqIdx  <= '0;
      modeReg <= '0;
      cur     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          cur     <= startDesc;
          inSeq   <= (op == OP_MODE);
          seqIdx  <= '0;
          modeReg <= wrData;
          byteSel <= 1'b0;
          waiting <= 1'b0;
          state   <= firstState(startDesc.op);
        end
      end else if (!waiting) begin
        waiting <= 1'b1;
      end else if (tmrDone) begin
        waiting <= 1'b0;
        state   <= nextState;
        if (advByte) byteSel <= 1'b1;
        if (opEnd) begin
          if (inSeq && seqIdx != 3'(LAST_STEP)) begin
            cur     <= nextDesc;
            seqIdx  <= seqIdx + 3'd1;
            byteSel <= 1'b0;
            state   <= firstState(nextDesc.op);
          end else begin
            inSeq <= 1'b0;
            done  <= 1'b1;
          end
        end
      end
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/irx_cfg_master.sv
module irx_cfg_master #(
  parameter int STEP_CLKS   = 4,
  parameter int LONG_STEPS  = 80,
  parameter int SHORT_STEPS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  input  logic [7:0] devAddr,
  input  logic [6:0] regIndex,
  input  logic [7:0] wrData,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  output logic       irClk,
  output logic       irData,
  input  logic       irValidN,
  input  logic       irRxBit
);
  import irx_cfg_pkg::*;

  localparam int LONG_CLKS  = STEP_CLKS * LONG_STEPS;
  localparam int SHORT_CLKS = STEP_CLKS * SHORT_STEPS;

  dpCtl_t ctl;
  logic   tmrDone, cntLast, validSeen;

  irx_cfg_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .op       (opCode_e'(op)),
    .devAddr  (devAddr),
    .regIndex (regIndex),
    .wrData   (wrData),
    .tmrDone  (tmrDone),
    .cntLast  (cntLast),
    .validSeen(validSeen),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  irx_cfg_dp #(.LONG_CLKS(LONG_CLKS), .SHORT_CLKS(SHORT_CLKS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .validNIn (irValidN),
    .rxBitIn  (irRxBit),
    .sclk     (irClk),
    .sdata    (irData),
    .rdData   (rdData),
    .tmrDone  (tmrDone),
    .cntLast  (cntLast),
    .validSeen(validSeen)
  );
endmodule

// File: rtl/irx_cfg_master_chk.sv
module irx_cfg_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] rdData,
  input logic       irClk,
  input logic       irData
);
  // R2: data only moves while the clock is low
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irClk && $past(irClk)) |-> $stable(irData));

  // R3 / R8: clock rests low whenever the engine is idle
  p_idle_clk_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !irClk);

  // R11: done lasts one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: done coincides with the engine being idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11: busy only begins in answer to a start request
  p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R11 / R5: read result holds outside an operation
  p_rd_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(rdData));
endmodule

bind irx_cfg_master irx_cfg_master_chk chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .rdData(rdData),
  .irClk (irClk),
  .irData(irData)
);

// File: tb/irx_cfg_master_tb_top.sv
`timescale 1ns/1ps
module irx_cfg_master_tb_top;
  localparam int STEP  = 1;
  localparam int LONGS = 8;
  localparam int SHORTS = 3;
  localparam int LONG_CLKS = STEP * LONGS;
  localparam int LOGSZ = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] devAddr = 8'h00;
  logic [6:0] regIndex = 7'h00;
  logic [7:0] wrData = 8'h00;
  logic busy, done, irClk, irData;
  logic [7:0] rdData;
  logic irValidN;
  logic irRxBit = 1'b0;

  always #5 clk = ~clk;

  irx_cfg_master #(.STEP_CLKS(STEP), .LONG_STEPS(LONGS), .SHORT_STEPS(SHORTS)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .devAddr(devAddr),
    .regIndex(regIndex), .wrData(wrData), .busy(busy), .done(done),
    .rdData(rdData), .irClk(irClk), .irData(irData),
    .irValidN(irValidN), .irRxBit(irRxBit)
  );

  int vectors = 0;
  int errors = 0;

  // transceiver model: logs data at every rising clock and answers reads
  logic logBits [LOGSZ];
  int totalRises = 0;
  int respStart = 0;
  int respK = 0;
  logic [7:0] respByte = 8'h00;

  assign irValidN = !(respK > 0 && (totalRises - respStart) >= 9 + respK);

  always @(posedge irClk) begin
    int rel;
    logBits[totalRises % LOGSZ] = irData;
    totalRises = totalRises + 1;
    rel = totalRises - respStart;
    if (respK > 0 && rel >= 10 + respK && rel < 18 + respK)
      irRxBit <= respByte[3'(rel - 10 - respK)];
  end

  // phase length monitor (R10)
  int minHigh = 1 << 20, minLow = 1 << 20, minSetup = 1 << 20;
  int clkRun = 0, dataRun = 0;
  logic prevClk = 1'b0, prevData = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (irData != prevData) dataRun = 0;
      if (irClk != prevClk) begin
        if (prevClk) begin if (clkRun < minHigh) minHigh = clkRun; end
        else begin
          if (clkRun < minLow) minLow = clkRun;
          if (dataRun < minSetup) minSetup = dataRun;
        end
        clkRun = 1;
      end else clkRun = clkRun + 1;
      dataRun = dataRun + 1;
      prevClk = irClk;
      prevData = irData;
    end
  end

  // expected edge sequence
  logic expBits [LOGSZ];
  int expN;

  task automatic addBit(input logic b);
    expBits[expN] = b;
    expN = expN + 1;
  endtask

  task automatic addWrite(input logic [7:0] cmd, input logic [7:0] d);
    addBit(1'b0);
    for (int i = 0; i < 8; i++) addBit(cmd[i]);
    for (int i = 0; i < 8; i++) addBit(d[i]);
    addBit(1'b0); addBit(1'b0);
  endtask

  task automatic addRead(input logic [7:0] cmd, input int k);
    addBit(1'b0);
    for (int i = 0; i < 8; i++) addBit(cmd[i]);
    if (k >= 1 && k <= 10) begin
      for (int i = 0; i < k; i++) addBit(i == 0 ? 1'b0 : 1'b1);
      for (int i = 0; i < 8; i++) addBit(1'b1);
    end else begin
      for (int i = 0; i < 10; i++) addBit(i == 0 ? 1'b0 : 1'b1);
      addBit(1'b1); addBit(1'b1);
    end
    addBit(1'b1);
    for (int i = 0; i < 3; i++) addBit(1'b0);
  endtask

  task automatic addReset();
    for (int i = 0; i < 30; i++) addBit(1'b0);
  endtask

  function automatic logic [7:0] mkCmd(input logic [7:0] a, input logic [6:0] ix, input logic w);
    return a | {ix, 1'b0} | {7'b0, w};
  endfunction

  function automatic logic [7:0] expRead(input int k, input logic [7:0] b);
    return (k >= 1 && k <= 10) ? b : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] o, input logic [7:0] a, input logic [6:0] ix,
                       input logic [7:0] d, input int k, input logic [7:0] rxb,
                       input bit poke, input string req);
    int base, mism, firstBad, cyc, doneCnt;
    logic [7:0] prevRd, expRd;
    bit isRead;
    expN = 0;
    isRead = 1'b0;
    prevRd = rdData;
    case (o)
      2'd0: addWrite(mkCmd(a, ix, 1'b1), d);
      2'd1: begin addRead(mkCmd(a, ix, 1'b0), k); isRead = 1'b1; end
      2'd2: addReset();
      default: begin
        addReset();
        addWrite(8'h41, 8'h17);
        addWrite(8'h43, d);
        addWrite(8'h45, 8'hFF);
        addRead(8'h42, k);
        isRead = 1'b1;
      end
    endcase
    base = totalRises;
    respK = k;
    respByte = rxb;
    respStart = base + ((o == 2'd3) ? 87 : 0);
    @(negedge clk);
    op = o; devAddr = a; regIndex = ix; wrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (150) @(negedge clk);
      op = 2'd2; wrData = ~d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    doneCnt = 0;
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    check(done === 1'b1, "R11", "done reached", int'(done), 1);
    check(busy === 1'b0, "R11", "busy low with done", int'(busy), 0);
    @(negedge clk);
    check(done === 1'b0, "R11", "done one cycle", int'(done), 0);
    mism = 0;
    firstBad = -1;
    for (int i = 0; i < expN; i++)
      if (logBits[(base + i) % LOGSZ] !== expBits[i]) begin
        mism = mism + 1;
        if (firstBad < 0) firstBad = i;
      end
    check(totalRises - base == expN, req, "rising edge count", totalRises - base, expN);
    check(mism == 0, req, "edge data (R1 R2) first bad index", firstBad, -1);
    check(irClk === 1'b0 && irData === 1'b0, "R7", "lines low at end",
          int'({irClk, irData}), 0);
    expRd = isRead ? expRead(k, rxb) : prevRd;
    check(rdData === expRd, isRead ? ((k >= 1 && k <= 10) ? "R5" : "R6") : "R11",
          "rdData", int'(rdData), int'(expRd));
    repeat (60) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R11", "quiet after op (poke ignored)",
          int'({busy, done}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, errors + 1);
    $finish;
  end

  initial begin
    int seedInit;
    logic [7:0] a, d, b;
    logic [6:0] ix;
    int k;
    seedInit = $urandom(32'h1234_5678);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(irClk === 1'b0 && irData === 1'b0, "R12", "lines after reset", int'({irClk, irData}), 0);
    check(busy === 1'b0 && done === 1'b0, "R12", "status after reset", int'({busy, done}), 0);
    check(rdData === 8'h00, "R12", "rdData after reset", int'(rdData), 0);

    // directed corners
    runOp(2'd0, 8'h40, 7'h00, 8'h17, 0, 8'h00, 1'b0, "R3");
    runOp(2'd2, 8'h00, 7'h00, 8'h00, 0, 8'h00, 1'b0, "R8");
    runOp(2'd1, 8'h40, 7'h01, 8'h00, 1, 8'hA5, 1'b0, "R4");
    runOp(2'd1, 8'h40, 7'h01, 8'h00, 10, 8'h3C, 1'b0, "R4");
    runOp(2'd1, 8'h40, 7'h02, 8'h00, 0, 8'hFF, 1'b0, "R6");
    runOp(2'd0, 8'h41, 7'h7F, 8'h80, 0, 8'h00, 1'b1, "R11");
    runOp(2'd3, 8'h00, 7'h00, 8'h5A, 3, 8'hC3, 1'b0, "R9");

    // random mix
    for (int n = 0; n < 16; n++) begin
      a = 8'($urandom); ix = 7'($urandom); d = 8'($urandom); b = 8'($urandom);
      k = $urandom_range(0, 10);
      if (n % 2 == 0) runOp(2'd0, a, ix, d, 0, 8'h00, 1'b0, "R3");
      else            runOp(2'd1, a, ix, d, k, b, 1'b0, "R4");
    end
    runOp(2'd3, 8'h00, 7'h00, 8'h0F, 0, 8'h00, 1'b0, "R9");

    check(minHigh >= LONG_CLKS, "R10", "shortest clock high", minHigh, LONG_CLKS);
    check(minLow >= LONG_CLKS, "R10", "shortest clock low", minLow, LONG_CLKS);
    check(minSetup >= LONG_CLKS, "R10", "shortest data setup", minSetup, LONG_CLKS);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule